// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three independent 16-bit up-counters behind a plain synchronous register port. Each channel has its own divider, which can be bypassed or set to divide the input clock by a power of two between 2 and 65536. Each channel also has its own run/stop control and a restart command. Every channel can run in one of two modes. In free-running mode it wraps at the end of its 16-bit range. In interval mode it wraps when it reaches a programmed limit and raises an event flag.

Software programs each channel through six registers. The registers of the three channels are interleaved, so that the same register of neighbouring channels lies 4 bytes apart. Software polls the live count, and it acknowledges events by reading the status register. Each channel's event flags are masked by that channel's enable bits, and the masked flags of all channels are merged into one registered interrupt line.

Top module: `tri_interval_timer`

## Requirements
- R1: After synchronous reset, all registers read 0 except counter control, which reads 0x0001 (stopped). `irq` and `bus_rdata` are 0.
- R2: Byte addresses for channel c (c = 0, 1, 2) are: clock control 0x00+4c, counter control 0x0C+4c, count 0x18+4c, interval 0x24+4c, status 0x54+4c, enable 0x60+4c. Writes to the count and status registers are ignored. A read of any other address returns 0.
- R3: Clock control bit 0 enables the divider, and bits [4:1] hold an exponent N. When the divider is enabled, the counter advances once every 2^(N+1) input clocks, counting from the last restart. When the divider is disabled, the counter advances on every clock.
- R4: While counter control bit 0 is 1, the counter and its divider hold their values.
- R5: A write with counter control bit 4 set clears the counter and the divider at that edge. Bit 4 reads back as 0 from the following cycle onwards.
- R6: When counter control bit 1 is 1 (interval mode), an advance from a count equal to the interval value loads 0 and sets status bit 0. When bit 1 is 0, the counter wraps from 0xFFFF to 0 and sets no status.
- R7: A read of the status register returns the flag and then clears it. If a new event arrives in the same cycle as that read, the flag stays set.
- R8: `irq` is 1 exactly one cycle after any channel has status bit 0 and enable bit 0 both set.
- R9: `bus_rdata` carries the addressed value, as it was before the read edge, one cycle after `bus_rd` is sampled. It is 0 after a cycle with no read.
- R10: Each channel counts only on its own settings. Accesses to one channel leave the others unchanged.
- R11: Counter control bits 2, 3 and 5 are stored and read back, and they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, registered |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Register writes and restarts act at the edge that samples them. The count moves at each edge where a divider tick is present. Read data appears one edge after the read is sampled. An interval event reaches the status flag at its own edge and reaches `irq` one edge later. The bench keeps a behavioural model that advances at the same rising edges as the design. It compares both outputs against the model at every falling edge, so every result is sampled half a cycle after the edge that produced it. The directed cases (divider count, restart read-back, status acknowledge, set-while-acknowledge and the 16-bit wrap) are timed by counting edges from the write, and their expected values are derived from those counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // byte offsets of channel 0; channel c adds CH_STRIDE * c
  localparam int unsigned OFS_CLK   = 'h00;
  localparam int unsigned OFS_CTRL  = 'h0C;
  localparam int unsigned OFS_CNT   = 'h18;
  localparam int unsigned OFS_IVL   = 'h24;
  localparam int unsigned OFS_STAT  = 'h54;
  localparam int unsigned OFS_IEN   = 'h60;
  localparam int unsigned CH_STRIDE = 4;

  // counter control field positions
  localparam int unsigned CTRL_W       = 6;
  localparam int unsigned CTRL_STOP    = 0;
  localparam int unsigned CTRL_IVLMODE = 1;
  localparam int unsigned CTRL_RESTART = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 6'h01;

  typedef struct packed {
    logic wr_clk;
    logic wr_ctrl;
    logic wr_ivl;
    logic wr_ien;
    logic rd_stat;
  } chan_strobe_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int unsigned PRE_W = 1 << EXP_W;

  logic [PRE_W-1:0] acc;
  logic [PRE_W-1:0] mask;

  // low N+1 bits set; the tick falls when they are all ones
  always_comb begin
    mask = ~({PRE_W{1'b1}} << ({1'b0, expo} + 1'b1));
    tick = run && (!pre_en || ((acc & mask) == mask));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (run)   acc <= acc + 1'b1;
  end

  // R3: with a divide of 4 or more, two ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && pre_en && expo != '0) |=> (!tick || !$stable(expo) || !pre_en));

  // R4: a stopped divider does not move
  p_pre_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(acc));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             wrap_mode,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             match_evt
);

  always_comb match_evt = tick && wrap_mode && (count == limit) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)     count <= '0;
    else if (match_evt) count <= '0;
    else if (tick)      count <= count + 1'b1;
  end

  // R4: without a tick the count holds
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(count));

  // R5: restart zeroes the count
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R6: free-running mode steps by one and wraps at the top
  p_freerun_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap_mode && !clr) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned EXP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  chan_strobe_t      stb,
  input  logic [CNT_W-1:0]  wdata,
  output logic [EXP_W:0]    clk_cfg,
  output logic [CTRL_W-1:0] ctrl_cfg,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  interval,
  output logic              stat,
  output logic              ien
);

  logic restart;
  logic run;
  logic tick;
  logic evt;

  always_comb begin
    restart = stb.wr_ctrl && wdata[CTRL_RESTART];
    run     = !ctrl_cfg[CTRL_STOP];
  end

  tmr_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .clr    (restart),
    .pre_en (clk_cfg[0]),
    .expo   (clk_cfg[EXP_W:1]),
    .tick   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .clr       (restart),
    .wrap_mode (ctrl_cfg[CTRL_IVLMODE]),
    .limit     (interval),
    .count     (count),
    .match_evt (evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_cfg  <= '0;
      ctrl_cfg <= CTRL_RST_VAL;
      interval <= '0;
      ien      <= 1'b0;
      stat     <= 1'b0;
    end else begin
      if (stb.wr_clk) clk_cfg <= wdata[EXP_W:0];
      if (stb.wr_ctrl) ctrl_cfg <= wdata[CTRL_W-1:0];
      else             ctrl_cfg[CTRL_RESTART] <= 1'b0;
      if (stb.wr_ivl) interval <= wdata;
      if (stb.wr_ien) ien <= wdata[0];
      // a new event outranks the acknowledge of the same cycle
      stat <= evt | (stat & ~stb.rd_stat);
    end
  end

  // R6: an interval match wraps to zero and raises the flag
  p_ivl_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    evt |=> (count == '0 && stat));

  // R7: an acknowledge without a new event clears the flag
  p_stat_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.rd_stat && !evt) |=> !stat);

  // R5: the restart bit lives for one cycle only
  p_restart_selfclr_r5: assert property (@(posedge clk) disable iff (rst)
    !stb.wr_ctrl |=> !ctrl_cfg[CTRL_RESTART]);

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);

  logic [EXP_W:0]    clk_cfg_v [N_CH];
  logic [CTRL_W-1:0] ctrl_v    [N_CH];
  logic [CNT_W-1:0]  cnt_v     [N_CH];
  logic [CNT_W-1:0]  ivl_v     [N_CH];
  logic [N_CH-1:0]   stat_v;
  logic [N_CH-1:0]   ien_v;
  logic [BUS_W-1:0]  rd_next;
  logic              src_any;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    chan_strobe_t stb;

    always_comb begin
      stb.wr_clk  = bus_wr && (bus_addr == ADDR_W'(OFS_CLK  + CH_STRIDE * c));
      stb.wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL + CH_STRIDE * c));
      stb.wr_ivl  = bus_wr && (bus_addr == ADDR_W'(OFS_IVL  + CH_STRIDE * c));
      stb.wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN  + CH_STRIDE * c));
      stb.rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STAT + CH_STRIDE * c));
    end

    tmr_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .stb      (stb),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .clk_cfg  (clk_cfg_v[c]),
      .ctrl_cfg (ctrl_v[c]),
      .count    (cnt_v[c]),
      .interval (ivl_v[c]),
      .stat     (stat_v[c]),
      .ien      (ien_v[c])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr == ADDR_W'(OFS_CLK  + CH_STRIDE * c)) rd_next = BUS_W'(clk_cfg_v[c]);
      if (bus_addr == ADDR_W'(OFS_CTRL + CH_STRIDE * c)) rd_next = BUS_W'(ctrl_v[c]);
      if (bus_addr == ADDR_W'(OFS_CNT  + CH_STRIDE * c)) rd_next = BUS_W'(cnt_v[c]);
      if (bus_addr == ADDR_W'(OFS_IVL  + CH_STRIDE * c)) rd_next = BUS_W'(ivl_v[c]);
      if (bus_addr == ADDR_W'(OFS_STAT + CH_STRIDE * c)) rd_next = BUS_W'(stat_v[c]);
      if (bus_addr == ADDR_W'(OFS_IEN  + CH_STRIDE * c)) rd_next = BUS_W'(ien_v[c]);
    end
    src_any = |(stat_v & ien_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_next : '0;
      irq       <= src_any;
    end
  end

  // R8: the line only rises for an enabled pending flag
  p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(src_any));

  // R8: an enabled pending flag always reaches the line
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    src_any |=> irq);

  // R9: no read, no data
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/tri_interval_timer_tb.sv
module tri_interval_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tri_interval_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // ---------------- behavioural model ----------------
  logic [4:0]  m_clk  [3];
  logic [5:0]  m_ctrl [3];
  logic [15:0] m_ivl  [3];
  logic [15:0] m_cnt  [3];
  logic [15:0] m_pre  [3];
  logic        m_stat [3];
  logic        m_ien  [3];
  logic        m_irq;
  logic [15:0] m_rdata;
  string       m_tag;

  function automatic logic [7:0] ad(int base, int c);
    return 8'(base + 4 * c);
  endfunction

  function automatic logic [15:0] pmask(logic [3:0] n);
    return 16'hFFFF >> (15 - int'(n));
  endfunction

  always @(posedge clk) begin : model
    logic [15:0] rv;
    string       tg;
    logic        ni, run, tick, evt, rdst;
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        m_clk[c] = '0; m_ctrl[c] = 6'h01; m_ivl[c] = '0; m_cnt[c] = '0;
        m_pre[c] = '0; m_stat[c] = 1'b0; m_ien[c] = 1'b0;
      end
      m_irq = 1'b0; m_rdata = '0; m_tag = "R9";
    end else begin
      rv = '0; tg = "R9";
      if (bus_rd) begin
        tg = "R2";
        for (int c = 0; c < 3; c++) begin
          if (bus_addr == ad('h00, c)) begin rv = {11'b0, m_clk[c]};  tg = "R3"; end
          if (bus_addr == ad('h0C, c)) begin rv = {10'b0, m_ctrl[c]}; tg = "R11/R5"; end
          if (bus_addr == ad('h18, c)) begin rv = m_cnt[c];           tg = "R6/R10"; end
          if (bus_addr == ad('h24, c)) begin rv = m_ivl[c];           tg = "R2"; end
          if (bus_addr == ad('h54, c)) begin rv = {15'b0, m_stat[c]}; tg = "R7"; end
          if (bus_addr == ad('h60, c)) begin rv = {15'b0, m_ien[c]};  tg = "R8"; end
        end
      end
      ni = 1'b0;
      for (int c = 0; c < 3; c++) ni = ni | (m_stat[c] & m_ien[c]);
      for (int c = 0; c < 3; c++) begin
        run  = !m_ctrl[c][0];
        tick = run && (!m_clk[c][0] ||
               ((m_pre[c] & pmask(m_clk[c][4:1])) == pmask(m_clk[c][4:1])));
        evt  = 1'b0;
        if (bus_wr && bus_addr == ad('h0C, c) && bus_wdata[4]) begin
          m_cnt[c] = '0; m_pre[c] = '0;
        end else begin
          if (tick) begin
            if (m_ctrl[c][1] && m_cnt[c] == m_ivl[c]) begin m_cnt[c] = '0; evt = 1'b1; end
            else m_cnt[c] = m_cnt[c] + 16'd1;
          end
          if (run) m_pre[c] = m_pre[c] + 16'd1;
        end
        rdst = bus_rd && bus_addr == ad('h54, c);
        m_stat[c] = evt | (m_stat[c] & !rdst);
        if (bus_wr && bus_addr == ad('h00, c)) m_clk[c] = bus_wdata[4:0];
        if (bus_wr && bus_addr == ad('h0C, c)) m_ctrl[c] = bus_wdata[5:0];
        else m_ctrl[c][4] = 1'b0;
        if (bus_wr && bus_addr == ad('h24, c)) m_ivl[c] = bus_wdata;
        if (bus_wr && bus_addr == ad('h60, c)) m_ien[c] = bus_wdata[0];
      end
      m_rdata = rv; m_irq = ni; m_tag = tg;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_tag, bus_rdata, m_rdata);
      chk("R8 irq", {15'b0, irq}, {15'b0, m_irq});
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_get(logic [7:0] a, output logic [15:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [15:0] exp, string tag);
    logic [15:0] v;
    rd_get(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v1, v2, d;
    int kind, ch;
    logic [7:0] a;
    void'($urandom(32'd20240607));
    idle(5);
    rst = 1'b0;

    // R1 reset values
    rd_chk(8'h0C, 16'h0001, "R1 ctrl reset");
    rd_chk(8'h20, 16'h0000, "R1 count reset");
    rd_chk(8'h54, 16'h0000, "R1 status reset");
    chk("R1 irq reset", {15'b0, irq}, 16'h0000);

    // R2 map, read-only and unmapped
    wr(8'h00, 16'h0015);
    rd_chk(8'h00, 16'h0015, "R2 clk readback");
    wr(8'h18, 16'h1234);
    rd_chk(8'h18, 16'h0000, "R2 count read-only");
    rd_chk(8'h30, 16'h0000, "R2 unmapped");
    wr(8'h00, 16'h0000);

    // R3 divide by 4 on channel 1: restart, 10 idle cycles -> 2 ticks
    wr(8'h04, 16'h0003);
    wr(8'h10, 16'h0010);
    idle(10);
    rd_chk(8'h1C, 16'd2, "R3 divided count");

    // R4 stop holds; R10 other channels untouched
    wr(8'h10, 16'h0001);
    rd_get(8'h1C, v1);
    idle(7);
    rd_get(8'h1C, v2);
    chk("R4 stopped count holds (R10)", v2, v1);

    // R5 restart bit self-clears
    wr(8'h14, 16'h0010);
    rd_chk(8'h14, 16'h0000, "R5 restart reads 0");

    // R6/R7/R8 interval 20 on channel 0
    wr(8'h24, 16'd20);
    wr(8'h60, 16'h0001);
    wr(8'h0C, 16'h0012);
    idle(22);
    chk("R8 irq after match", {15'b0, irq}, 16'h0001);
    rd_chk(8'h54, 16'h0001, "R7 status set");
    rd_chk(8'h54, 16'h0000, "R7 status cleared by read");
    chk("R8 irq after ack", {15'b0, irq}, 16'h0000);

    // R7 set wins over acknowledge: interval 1, events on every second edge
    wr(8'h24, 16'd1);
    wr(8'h0C, 16'h0012);
    rd_chk(8'h54, 16'h0000, "R7 before first event");
    rd_chk(8'h54, 16'h0001, "R7 event with read");
    rd_chk(8'h54, 16'h0001, "R7 set kept over ack");
    wr(8'h0C, 16'h0001);
    rd_get(8'h54, v1);

    // R11 spare bits stored
    wr(8'h10, 16'h002D);
    rd_chk(8'h10, 16'h002D, "R11 spare bits");

    // R6 free-running wrap on channel 2
    wr(8'h14, 16'h0010);
    idle(65540);
    rd_chk(8'h20, 16'd5, "R6 16-bit wrap");
    rd_chk(8'h5C, 16'h0000, "R6 no status in free mode");

    // random phase, checked by the model (R10 across channels)
    for (int i = 0; i < 3000; i++) begin
      kind = $urandom % 7;
      ch   = $urandom % 3;
      case (kind)
        0: begin a = ad('h00, ch); d = 16'(($urandom % 4) << 1) | 16'($urandom % 2); end
        1: begin a = ad('h0C, ch); d = 16'($urandom & 32'h3E) | 16'(($urandom % 4) == 0); end
        2: begin a = ad('h24, ch); d = 16'($urandom % 40); end
        3: begin a = ad('h60, ch); d = 16'($urandom % 2); end
        4: begin a = ad('h18, ch); d = 16'($urandom); end
        5: begin a = ad('h54, ch); d = 16'($urandom); end
        default: begin a = 8'h30; d = 16'($urandom); end
      endcase
      case ($urandom % 4)
        0: wr(a, d);
        1, 2: rd_get(a, v1);
        default: idle(1 + $urandom % 3);
      endcase
    end
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule